// File: doc/BRIEF.md
# Octal DTR Flash Mode-Switch Sequencer

This block sits on the controller side of a serial NOR flash. It moves the device between single-line SPI (1-1-1) and octal double-transfer-rate (8d-8d-8d) operation, and then confirms that the change took effect. Software or a boot engine raises a request with a direction bit. The sequencer then issues a fixed series of commands through a command-level port to a lower transaction engine. It finishes with a one-cycle done pulse and a sticky error flag.

Every command is a single bundle of fields: opcode, extension byte, protocol, address and address-byte count, dummy count, direction, data flag and write byte. The engine answers each command with a completion pulse and a read byte. The switch is confirmed by reading the mode register back in the new protocol. It is never confirmed by an identification read, because that read returns single-rate data even in octal mode. The current mode is held in a register. It changes only after a read-back that matches, and it selects the protocol used for write-enable, status polling and configuration writes.

Top module: `octal_mode_sequencer`

## Requirements
- R1: After reset, busy_o, done_o, err_o, cmd_valid_o and octal_mode_o are all 0, where octal_mode_o = 0 means SPI.
- R2: An enable request issues these commands in order. First a write-enable (opcode 0x06, no address, no data). Then a configuration write (opcode 0x72, 4 address bytes, address 0x300, data 0x00). Then status reads (opcode 0x05) repeat until bit 0 of the returned byte is 0. Then a second write-enable. Then a configuration write of 0x02 to address 0x000. Last comes a configuration read (opcode 0x71, 4 address bytes, address 0x000, one data byte in).
- R3: A disable request issues only three commands. The first is a write-enable. The second is a configuration write of 0x00 to address 0x000, sent in the current protocol. The third is a configuration read of address 0x000, sent in 1-1-1 (cmd_proto_o = 0) with 0 dummy cycles. During an enable, the mode read is sent in 8d-8d-8d (cmd_proto_o = 1) with 4 dummy cycles.
- R4: Write-enable, status reads and configuration writes use the protocol given by octal_mode_o. In 8d-8d-8d, cmd_ext_o is the bitwise inverse of cmd_opcode_o. In 1-1-1, cmd_ext_o is 0x00.
- R5: A status read in 8d-8d-8d carries 4 address bytes (address 0) and 4 dummy cycles. In 1-1-1 it carries 0 address bytes and 0 dummy cycles.
- R6: A read-back that equals the value written (0x02 for enable, 0x00 for disable) ends the sequence with done_o = 1 and err_o = 0, and octal_mode_o then takes the requested mode.
- R7: A read-back that differs from the value written ends the sequence with done_o = 1 and err_o = 1. octal_mode_o is left unchanged.
- R8: If poll_limit_i consecutive status reads all return bit 0 = 1, the sequence ends with done_o = 1 and err_o = 1 and no further commands are issued. A limit of 0 behaves as 1.
- R9: req_i is ignored while busy_o = 1. No extra commands follow, and the mode is not affected.
- R10: done_o is high for exactly one cycle. err_o keeps its value until the next accepted request, which clears it.
- R11: cmd_valid_o stays high with stable fields until cmd_done_i. It is low in the cycle after each completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a mode switch (taken only when idle) |
| req_enable_i | input | 1 | 1 = switch to 8d-8d-8d, 0 = switch to 1-1-1 |
| poll_limit_i | input | POLL_W | Maximum status reads before timeout |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Last sequence failed (verify or timeout) |
| octal_mode_o | output | 1 | Current device mode, 1 = 8d-8d-8d |
| cmd_valid_o | output | 1 | Command fields valid |
| cmd_proto_o | output | 1 | 0 = 1-1-1, 1 = 8d-8d-8d |
| cmd_opcode_o | output | 8 | Command opcode |
| cmd_ext_o | output | 8 | Command extension byte |
| cmd_addr_o | output | ADDR_W | Address |
| cmd_addr_bytes_o | output | 3 | Number of address bytes |
| cmd_dummy_o | output | 5 | Dummy cycles |
| cmd_read_o | output | 1 | 1 = data phase reads from flash |
| cmd_has_data_o | output | 1 | Command has a one-byte data phase |
| cmd_wdata_o | output | 8 | Write data byte |
| cmd_done_i | input | 1 | Engine completion pulse |
| cmd_rdata_i | input | 8 | Byte read by the engine |

## Verification
The in-line assertions check several rules on every cycle. Done is a single-cycle pulse, and error rises only together with it. The mode register changes only on a successful finish. Every configuration write is entered straight from a write-enable. The command valid drops after each completion, and the poll counter never wraps. The exact command order, and the protocol, extension, address and dummy fields of each step, can only be shown by the bench's scenarios. The same holds for the protocol flip between enable and disable, octal-mode polling, verify mismatch, poll timeout and requests ignored while busy. Those scenarios compare every issued command against an expected queue.

// File: rtl/oms_pkg.sv
package oms_pkg;
  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_WCFG = 8'h72;
  localparam logic [7:0] OPC_RCFG = 8'h71;
  localparam logic [31:0] ADDR_RDCFG = 32'h0000_0300;
  localparam logic [31:0] ADDR_MODE  = 32'h0000_0000;
  localparam logic [7:0] VAL_OCT   = 8'h02;
  localparam logic [7:0] VAL_SPI   = 8'h00;
  localparam logic [7:0] VAL_DMY20 = 8'h00;
  localparam int DUMMY_W = 5;
  localparam logic [DUMMY_W-1:0] OCT_DUMMY = 5'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WEN_A, ST_WR_RDCFG, ST_POLL, ST_WEN_B, ST_WR_MODE, ST_RD_MODE
  } oms_state_e;

  typedef enum logic [2:0] {
    STP_WREN, STP_WR_RDCFG, STP_RDSR, STP_WR_MODE, STP_RD_MODE
  } oms_step_e;
endpackage

// File: rtl/oms_poll_cnt.sv
module oms_poll_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  // reads so far including the current one reach the limit
  assign last_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i};

  // R8
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> cnt_q != '1);
endmodule

// File: rtl/oms_cmd_fmt.sv
module oms_cmd_fmt import oms_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  oms_step_e           step_i,
  input  logic                octal_i,
  input  logic                target_i,
  output logic [7:0]          opc_o,
  output logic [7:0]          ext_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [2:0]          abytes_o,
  output logic [DUMMY_W-1:0]  dummy_o,
  output logic                rd_o,
  output logic                has_data_o,
  output logic [7:0]          wdata_o
);
  always_comb begin
    opc_o      = OPC_WREN;
    addr_o     = '0;
    abytes_o   = 3'd0;
    dummy_o    = '0;
    rd_o       = 1'b0;
    has_data_o = 1'b0;
    wdata_o    = 8'h00;
    case (step_i)
      STP_WR_RDCFG: begin
        opc_o = OPC_WCFG; abytes_o = 3'd4; addr_o = ADDR_RDCFG[ADDR_W-1:0];
        has_data_o = 1'b1; wdata_o = VAL_DMY20;
      end
      STP_RDSR: begin
        opc_o = OPC_RDSR; rd_o = 1'b1; has_data_o = 1'b1;
        if (octal_i) begin
          abytes_o = 3'd4; dummy_o = OCT_DUMMY;
        end
      end
      STP_WR_MODE: begin
        opc_o = OPC_WCFG; abytes_o = 3'd4; addr_o = ADDR_MODE[ADDR_W-1:0];
        has_data_o = 1'b1; wdata_o = target_i ? VAL_OCT : VAL_SPI;
      end
      STP_RD_MODE: begin
        opc_o = OPC_RCFG; abytes_o = 3'd4; addr_o = ADDR_MODE[ADDR_W-1:0];
        rd_o = 1'b1; has_data_o = 1'b1;
        dummy_o = octal_i ? OCT_DUMMY : '0;
      end
      default: ;
    endcase
    ext_o = octal_i ? ~opc_o : 8'h00;
  end
endmodule

// File: rtl/oms_ctrl.sv
module oms_ctrl import oms_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       req_en_i,
  input  logic       cmd_done_i,
  input  logic [7:0] rdata_i,
  input  logic       poll_last_i,
  output logic       poll_inc_o,
  output logic       poll_clr_o,
  output oms_step_e  step_o,
  output logic       proto_o,
  output logic       target_o,
  output logic       cmd_valid_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic       mode_o
);
  oms_state_e state_q, state_d;
  logic target_q, target_d, mode_q, mode_d, err_q, err_d, done_q, done_d, gap_q;
  logic ack;

  assign cmd_valid_o = (state_q != ST_IDLE) && !gap_q;
  assign ack         = cmd_done_i && cmd_valid_o;

  always_comb begin
    state_d = state_q; target_d = target_q; mode_d = mode_q;
    err_d = err_q; done_d = 1'b0; poll_inc_o = 1'b0; poll_clr_o = 1'b0;
    case (state_q)
      ST_IDLE: if (req_i) begin
        target_d = req_en_i; err_d = 1'b0; poll_clr_o = 1'b1; state_d = ST_WEN_A;
      end
      ST_WEN_A:    if (ack) state_d = target_q ? ST_WR_RDCFG : ST_WR_MODE;
      ST_WR_RDCFG: if (ack) state_d = ST_POLL;
      ST_POLL: if (ack) begin
        if (!rdata_i[0]) state_d = ST_WEN_B;
        else if (poll_last_i) begin
          err_d = 1'b1; done_d = 1'b1; state_d = ST_IDLE;
        end else poll_inc_o = 1'b1;
      end
      ST_WEN_B:   if (ack) state_d = ST_WR_MODE;
      ST_WR_MODE: if (ack) state_d = ST_RD_MODE;
      ST_RD_MODE: if (ack) begin
        done_d = 1'b1; state_d = ST_IDLE;
        if (rdata_i == (target_q ? VAL_OCT : VAL_SPI)) mode_d = target_q;
        else err_d = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; target_q <= 1'b0; mode_q <= 1'b0;
      err_q <= 1'b0; done_q <= 1'b0; gap_q <= 1'b0;
    end else begin
      state_q <= state_d; target_q <= target_d; mode_q <= mode_d;
      err_q <= err_d; done_q <= done_d; gap_q <= ack;
    end
  end

  always_comb begin
    case (state_q)
      ST_WR_RDCFG: step_o = STP_WR_RDCFG;
      ST_POLL:     step_o = STP_RDSR;
      ST_WR_MODE:  step_o = STP_WR_MODE;
      ST_RD_MODE:  step_o = STP_RD_MODE;
      default:     step_o = STP_WREN;
    endcase
  end

  // read-back runs in the new protocol, everything else in the current one
  assign proto_o  = (state_q == ST_RD_MODE) ? target_q : mode_q;
  assign target_o = target_q;
  assign busy_o   = state_q != ST_IDLE;
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign mode_o   = mode_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R10
  err_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> done_q);
  // R6
  mode_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> done_q && !err_q);
  // R2
  wren_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WR_RDCFG || state_q == ST_WR_MODE) && !$stable(state_q))
      |-> ($past(state_q) == ST_WEN_A || $past(state_q) == ST_WEN_B));
  // R11
  gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_done_i && cmd_valid_o) |=> !cmd_valid_o);
endmodule

// File: rtl/octal_mode_sequencer.sv
module octal_mode_sequencer import oms_pkg::*; #(
  parameter int POLL_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               req_enable_i,
  input  logic [POLL_W-1:0]  poll_limit_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic               octal_mode_o,
  output logic               cmd_valid_o,
  output logic               cmd_proto_o,
  output logic [7:0]         cmd_opcode_o,
  output logic [7:0]         cmd_ext_o,
  output logic [ADDR_W-1:0]  cmd_addr_o,
  output logic [2:0]         cmd_addr_bytes_o,
  output logic [DUMMY_W-1:0] cmd_dummy_o,
  output logic               cmd_read_o,
  output logic               cmd_has_data_o,
  output logic [7:0]         cmd_wdata_o,
  input  logic               cmd_done_i,
  input  logic [7:0]         cmd_rdata_i
);
  oms_step_e step;
  logic proto, target, poll_inc, poll_clr, poll_last;

  oms_ctrl u_ctrl (
    .clk_i, .rst_ni, .req_i, .req_en_i(req_enable_i),
    .cmd_done_i, .rdata_i(cmd_rdata_i), .poll_last_i(poll_last),
    .poll_inc_o(poll_inc), .poll_clr_o(poll_clr), .step_o(step),
    .proto_o(proto), .target_o(target), .cmd_valid_o, .busy_o,
    .done_o, .err_o, .mode_o(octal_mode_o)
  );

  oms_poll_cnt #(.W(POLL_W)) u_poll (
    .clk_i, .rst_ni, .clr_i(poll_clr), .inc_i(poll_inc),
    .limit_i(poll_limit_i), .last_o(poll_last)
  );

  oms_cmd_fmt #(.ADDR_W(ADDR_W)) u_fmt (
    .step_i(step), .octal_i(proto), .target_i(target),
    .opc_o(cmd_opcode_o), .ext_o(cmd_ext_o), .addr_o(cmd_addr_o),
    .abytes_o(cmd_addr_bytes_o), .dummy_o(cmd_dummy_o), .rd_o(cmd_read_o),
    .has_data_o(cmd_has_data_o), .wdata_o(cmd_wdata_o)
  );

  assign cmd_proto_o = proto;
endmodule

// File: tb/tb_octal_mode_sequencer.sv
module tb_octal_mode_sequencer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_en = 1'b0;
  logic [15:0] limit = 16'd8;
  logic busy, done, err, mode, valid, proto, rd, hd;
  logic [7:0] opc, ext, wd;
  logic [31:0] addr;
  logic [2:0] ab;
  logic [4:0] dm;
  logic cmd_done = 1'b0;
  logic [7:0] cmd_rdata = 8'h00;

  int n_cmp = 0, n_bad = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  octal_mode_sequencer dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_enable_i(req_en),
    .poll_limit_i(limit), .busy_o(busy), .done_o(done), .err_o(err),
    .octal_mode_o(mode), .cmd_valid_o(valid), .cmd_proto_o(proto),
    .cmd_opcode_o(opc), .cmd_ext_o(ext), .cmd_addr_o(addr),
    .cmd_addr_bytes_o(ab), .cmd_dummy_o(dm), .cmd_read_o(rd),
    .cmd_has_data_o(hd), .cmd_wdata_o(wd), .cmd_done_i(cmd_done),
    .cmd_rdata_i(cmd_rdata)
  );

  typedef struct {
    logic [66:0] f;
    logic [7:0]  rsp;
    string       tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // R4: extension is the inverted opcode only in octal
  task automatic push(input logic [7:0] o, input logic p, input logic [31:0] a,
                      input logic [2:0] b, input logic [4:0] d, input logic r,
                      input logic h, input logic [7:0] w, input logic [7:0] rsp,
                      input string tag);
    exp_t e;
    e.f = {o, (p ? ~o : 8'h00), p, a, b, d, r, h, w};
    e.rsp = rsp; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic x_wren(input logic p, input string t);
    push(8'h06, p, 32'h0, 3'd0, 5'd0, 1'b0, 1'b0, 8'h00, 8'h00, t);
  endtask
  task automatic x_wcfg(input logic p, input logic [31:0] a, input logic [7:0] w, input string t);
    push(8'h72, p, a, 3'd4, 5'd0, 1'b0, 1'b1, w, 8'h00, t);
  endtask
  // R5
  task automatic x_rdsr(input logic p, input logic [7:0] rsp, input string t);
    push(8'h05, p, 32'h0, p ? 3'd4 : 3'd0, p ? 5'd4 : 5'd0, 1'b1, 1'b1, 8'h00, rsp, t);
  endtask
  task automatic x_rcfg(input logic p, input logic [7:0] rsp, input string t);
    push(8'h71, p, 32'h0, 3'd4, p ? 5'd4 : 5'd0, 1'b1, 1'b1, 8'h00, rsp, t);
  endtask

  // engine model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && valid) begin
        exp_t e;
        logic [66:0] act;
        act = {opc, ext, proto, addr, ab, dm, rd, hd, wd};
        if (q.size() == 0) begin
          chk("R9 unexpected command", act, 67'h0);
          e.rsp = 8'h00; e.f = act;
        end else begin
          e = q.pop_front();
          chk(e.tag, act, e.f);
        end
        repeat (2) @(negedge clk);
        chk("R11 fields stable while valid", {valid, opc, ext, proto, addr, ab, dm, rd, hd, wd},
            {1'b1, act});
        cmd_done = 1'b1; cmd_rdata = e.rsp;
        @(negedge clk);
        cmd_done = 1'b0; cmd_rdata = 8'h00;
        chk("R11 valid low after completion", valid, 1'b0);
      end
    end
  end

  task automatic request(input logic en);
    @(negedge clk); req = 1'b1; req_en = en;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic finish_seq(input string t, input logic exp_err, input logic exp_mode);
    int k = 0;
    while (!done && k < 2000) begin @(negedge clk); k++; end
    chk({t, " done seen"}, done, 1'b1);
    chk({t, " err"}, err, exp_err);
    chk({t, " mode"}, mode, exp_mode);
    chk({t, " all commands issued"}, q.size(), 0);
    @(negedge clk);
    chk("R10 done one cycle", done, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1; n_cmp++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reset outputs", {busy, done, err, mode, valid}, 5'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {busy, valid}, 2'b0);

    // R2 R5 R6: enable from SPI, two busy polls
    x_wren(0, "R2 wren A");
    x_wcfg(0, 32'h300, 8'h00, "R2 dummy-cfg write");
    x_rdsr(0, 8'h01, "R5 poll spi 1"); x_rdsr(0, 8'h03, "R5 poll spi 2");
    x_rdsr(0, 8'h00, "R5 poll spi 3");
    x_wren(0, "R2 wren B");
    x_wcfg(0, 32'h0, 8'h02, "R3 mode write spi");
    x_rcfg(1, 8'h02, "R3 readback octal");
    request(1);
    chk("R2 busy after request", busy, 1'b1);
    finish_seq("R6 enable", 1'b0, 1'b1);

    // R4 R5: enable again while already octal
    x_wren(1, "R4 wren octal");
    x_wcfg(1, 32'h300, 8'h00, "R4 dummy-cfg octal");
    x_rdsr(1, 8'h00, "R5 poll octal");
    x_wren(1, "R4 wren octal B");
    x_wcfg(1, 32'h0, 8'h02, "R4 mode write octal");
    x_rcfg(1, 8'h02, "R4 readback octal");
    request(1);
    finish_seq("R5 re-enable", 1'b0, 1'b1);

    // R3 R9: disable, with an ignored request mid-way
    x_wren(1, "R3 wren octal");
    x_wcfg(1, 32'h0, 8'h00, "R3 mode write octal");
    x_rcfg(0, 8'h00, "R3 readback spi");
    request(0);
    chk("R9 busy before extra request", busy, 1'b1);
    request(1);
    finish_seq("R3 disable", 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    chk("R9 no command after ignored request", {valid, busy, mode}, 3'b0);

    // R7: verify mismatch
    x_wren(0, "R7 wren A"); x_wcfg(0, 32'h300, 8'h00, "R7 dummy-cfg");
    x_rdsr(0, 8'h00, "R7 poll"); x_wren(0, "R7 wren B");
    x_wcfg(0, 32'h0, 8'h02, "R7 mode write");
    x_rcfg(1, 8'h00, "R7 readback");
    request(1);
    finish_seq("R7 mismatch", 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    chk("R10 err held", err, 1'b1);

    // R8: poll timeout with limit 3
    limit = 16'd3;
    x_wren(0, "R8 wren"); x_wcfg(0, 32'h300, 8'h00, "R8 dummy-cfg");
    x_rdsr(0, 8'h01, "R8 poll 1"); x_rdsr(0, 8'h01, "R8 poll 2");
    x_rdsr(0, 8'h01, "R8 poll 3");
    request(1);
    chk("R10 err cleared on accept", err, 1'b0);
    finish_seq("R8 timeout", 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    chk("R8 no command after timeout", valid, 1'b0);

    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule